// File: doc/BRIEF.md
# Refresh Row Address Extender

This block widens the refresh row address of a processor whose built-in refresh counter has only seven bits. Such a counter reaches just 128 rows. Memory modules that need 256, 512, 1024 or 2048 refresh rows would otherwise leave their upper rows unrefreshed. The block watches the processor's refresh cycles and keeps a small extension counter. It presents that counter above the seven processor bits, and the resulting row address feeds the DRAM row multiplexer during refresh.

The extension counter has no free-running clock of its own and does not need to be in phase with the processor's counter. It advances once each time the seven-bit counter wraps. The wrap is detected in one of two ways, chosen by a parameter. The first way matches one fixed seven-bit row value. The second way sees bit 6 drop from 1 to 0, compared with the value it had at the previous refresh. Higher extension bits act as a ripple carry. The design samples each refresh cycle once, on the rising edge of the qualified strobe. It commits the carry when that strobe ends, so the extension bits stay constant while a strobe is active.

Top module: `rfx_refresh_row_ext`

## Requirements
- R1: After reset, the extension bits are zero. The first refresh cycle shows zeros in row_o above bit 6.
- R2: While rfsh_act_i is high, row_vld_o is 1 and row_o equals the extension bits concatenated above cpu_row_i. row_o[6:0] follows cpu_row_i.
- R3: While rfsh_act_i is low, row_o is all zeros and row_vld_o is 0.
- R4: In match mode (TRIG_MODE = TRIG_MATCH, MATCH_ROW default 7'h7F), a trigger occurs when cpu_row_i equals MATCH_ROW on the first clock of a refresh strobe. Such a refresh cycle adds one to the extension bits. The new value appears from the next refresh cycle onward.
- R5: The extension bits count in binary. Bit k toggles only when a trigger occurs and all lower extension bits are 1. After 2^EXT_W triggers the count wraps from all ones to zero.
- R6: A strobe held for several clocks counts at most once. A change of cpu_row_i after the strobe's first clock does not trigger.
- R7: cpu_row_i equal to MATCH_ROW while rfsh_act_i is low has no effect. Non-matching rows during refresh also have no effect.
- R8: The extension bits do not change while rfsh_act_i stays high. They change only on the clock after the strobe falls.
- R9: In bit-6 mode (TRIG_MODE = TRIG_BIT6_FALL), a trigger occurs when cpu_row_i[6] is 0 on the first clock of a strobe and was 1 on the first clock of the previous strobe. The register that holds the previous value resets to 0.
- R10: In match mode, 128 x 2^EXT_W consecutive refreshes of rows 0,1,...,127 repeating, starting from reset, present every extended row address exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously and released on the clock |
| rfsh_act_i | input | 1 | Qualified refresh strobe (refresh and memory request both active), high true |
| cpu_row_i | input | 7 | Low seven address lines driven by the processor during refresh |
| row_o | output | 7+EXT_W | Extended refresh row address, zero outside refresh |
| row_vld_o | output | 1 | High while row_o carries a refresh row |

## Verification
Two events can arrive back to back. One is the end of a strobe that commits a pending carry. The other is the start of the next strobe, which must already show the advanced value. The bench provokes this by separating most refresh strobes with a single idle clock. The scoreboard then judges the first sampled clock of each new strobe against the model's incremented extension value. A second collision happens at a multi-bit ripple: the processor's wrap coincides with every lower extension bit being 1. The full sweep and a second wrapping sweep provoke it, and the monitor compares each clock of every strobe for both trigger variants.

// File: rtl/rfx_pkg.sv
package rfx_pkg;

  localparam int CPU_ROW_W = 7;

  typedef enum logic {
    TRIG_MATCH     = 1'b0,
    TRIG_BIT6_FALL = 1'b1
  } trig_mode_e;

endpackage

// File: rtl/rfx_rst_sync.sv
module rfx_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_no = stage_q[1];

endmodule

// File: rtl/rfx_strobe_edge.sv
module rfx_strobe_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic start_o,
  output logic stop_o
);

  logic act_q;
  logic act_d;

  always_comb begin
    act_d   = act_i;
    start_o = act_i & ~act_q;
    stop_o  = ~act_i & act_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
    end else begin
      act_q <= act_d;
    end
  end

endmodule

// File: rtl/rfx_carry_trig.sv
module rfx_carry_trig
  import rfx_pkg::*;
#(
  parameter trig_mode_e           TRIG_MODE = TRIG_MATCH,
  parameter logic [CPU_ROW_W-1:0] MATCH_ROW = '1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [CPU_ROW_W-1:0] cpu_row_i,
  output logic                 trig_o
);

  localparam int MSB = CPU_ROW_W - 1;

  generate
    if (TRIG_MODE == TRIG_MATCH) begin : g_match
      always_comb begin
        trig_o = start_i & (cpu_row_i == MATCH_ROW);
      end
    end else begin : g_bit6
      logic msb_q;
      logic msb_d;
      logic msb_en;

      always_comb begin
        msb_en = start_i;
        msb_d  = cpu_row_i[MSB];
        trig_o = start_i & ~cpu_row_i[MSB] & msb_q;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          msb_q <= 1'b0;
        end else if (msb_en) begin
          msb_q <= msb_d;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/rfx_ext_counter.sv
module rfx_ext_counter #(
  parameter int EXT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             commit_i,
  output logic [EXT_W-1:0] ext_o
);

  logic             pend_q;
  logic             pend_d;
  logic [EXT_W-1:0] ext_q;
  logic [EXT_W-1:0] ext_d;
  logic [EXT_W:0]   carry;

  always_comb begin
    pend_d = pend_q;
    if (commit_i) begin
      pend_d = 1'b0;
    end else if (arm_i) begin
      pend_d = 1'b1;
    end
  end

  assign carry[0] = commit_i & pend_q;

  generate
    for (genvar k = 0; k < EXT_W; k++) begin : g_bit
      assign carry[k+1] = carry[k] & ext_q[k];
      assign ext_d[k]   = ext_q[k] ^ carry[k];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ext_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (carry[0]) begin
        ext_q <= ext_d;
      end
    end
  end

  assign ext_o = ext_q;

endmodule

// File: rtl/rfx_refresh_row_ext.sv
module rfx_refresh_row_ext
  import rfx_pkg::*;
#(
  parameter int                   EXT_W     = 2,
  parameter trig_mode_e           TRIG_MODE = TRIG_MATCH,
  parameter logic [CPU_ROW_W-1:0] MATCH_ROW = '1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rfsh_act_i,
  input  logic [CPU_ROW_W-1:0]       cpu_row_i,
  output logic [CPU_ROW_W+EXT_W-1:0] row_o,
  output logic                       row_vld_o
);

  localparam int ROW_W = CPU_ROW_W + EXT_W;

  logic             rst_n_int;
  logic             start_w;
  logic             stop_w;
  logic             trig_w;
  logic [EXT_W-1:0] ext_w;

  rfx_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_int)
  );

  rfx_strobe_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .act_i   (rfsh_act_i),
    .start_o (start_w),
    .stop_o  (stop_w)
  );

  rfx_carry_trig #(
    .TRIG_MODE (TRIG_MODE),
    .MATCH_ROW (MATCH_ROW)
  ) u_trig (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .start_i   (start_w),
    .cpu_row_i (cpu_row_i),
    .trig_o    (trig_w)
  );

  rfx_ext_counter #(
    .EXT_W (EXT_W)
  ) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .arm_i    (trig_w),
    .commit_i (stop_w),
    .ext_o    (ext_w)
  );

  always_comb begin
    row_vld_o = rfsh_act_i;
    row_o     = '0;
    if (rfsh_act_i) begin
      row_o = ROW_W'({ext_w, cpu_row_i});
    end
  end

endmodule

// File: rtl/rfx_refresh_row_ext_chk.sv
module rfx_refresh_row_ext_chk #(
  parameter int EXT_W = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rfsh_act_i,
  input logic [EXT_W+6:0]   row_o,
  input logic               row_vld_o,
  input logic [EXT_W-1:0]   ext_i
);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R1: assert (ext_i == '0);
    end
  end

  assert_idle_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rfsh_act_i |-> (row_o == '0) && !row_vld_o);

  assert_step_one_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ext_i) |-> ext_i == EXT_W'($past(ext_i) + 1'b1));

  assert_held_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfsh_act_i && $past(rfsh_act_i)) |-> $stable(ext_i));

  assert_change_after_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ext_i) |-> !$past(rfsh_act_i) && $past(rfsh_act_i, 2));

endmodule

bind rfx_refresh_row_ext rfx_refresh_row_ext_chk #(
  .EXT_W (EXT_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rfsh_act_i (rfsh_act_i),
  .row_o      (row_o),
  .row_vld_o  (row_vld_o),
  .ext_i      (ext_w)
);

// File: tb/rfx_refresh_row_ext_tb_top.sv
module rfx_refresh_row_ext_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int EXT_W      = 2;
  localparam int ROW_W      = 7 + EXT_W;
  localparam int ROWS       = 128 << EXT_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             act;
  logic [6:0]       cpu;
  logic [ROW_W-1:0] row_a, row_b;
  logic             vld_a, vld_b;

  int checks = 0;
  int errors = 0;

  logic [EXT_W-1:0] q_a[$];
  logic [EXT_W-1:0] q_b[$];
  logic [EXT_W-1:0] exp_a, exp_b;
  logic             prev6_b;
  logic             act_prev;
  logic             mon_on;
  logic             sweep_on;
  bit               seen [0:ROWS-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  rfx_refresh_row_ext #(.EXT_W(EXT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rfsh_act_i(act), .cpu_row_i(cpu),
    .row_o(row_a), .row_vld_o(vld_a));

  rfx_refresh_row_ext #(.EXT_W(EXT_W), .TRIG_MODE(rfx_pkg::TRIG_BIT6_FALL)) dut_b6_i (
    .clk_i(clk), .rst_ni(rst_n), .rfsh_act_i(act), .cpu_row_i(cpu),
    .row_o(row_b), .row_vld_o(vld_b));

  task automatic chk(input string tag, input logic [31:0] actual, input logic [31:0] expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, actual, expected);
    end
  endtask

  // Driver: pushes the expected extension values, then runs one refresh strobe.
  task automatic refresh(input logic [6:0] r, input int hold, input logic [6:0] r_mid, input int gap);
    logic trig_b;
    q_a.push_back(exp_a);
    q_b.push_back(exp_b);
    trig_b = (r[6] == 1'b0) && prev6_b;
    prev6_b = r[6];
    act = 1'b1;
    cpu = r;
    @(posedge clk); #1;
    if (hold > 1) begin
      cpu = r_mid;
      repeat (hold - 1) begin @(posedge clk); #1; end
    end
    act = 1'b0;
    cpu = 7'h7F;
    if (r == 7'h7F) exp_a = exp_a + 1'b1;
    if (trig_b)     exp_b = exp_b + 1'b1;
    repeat (gap) begin @(posedge clk); #1; end
  endtask

  // Monitor: scoreboard compare on the falling clock edge.
  always @(negedge clk) begin
    if (mon_on) begin
      if (act) begin
        chk("R2 vld", {31'd0, vld_a}, 32'd1);
        chk("R2/R4/R5/R8 match-mode row", 32'(row_a), 32'({q_a[0], cpu}));
        chk("R9 bit6-mode row", 32'(row_b), 32'({q_b[0], cpu}));
        if (sweep_on) seen[row_a] = 1'b1;
      end else begin
        chk("R3 idle row", 32'(row_a), 32'd0);
        chk("R3 idle vld", {31'd0, vld_a | vld_b}, 32'd0);
        chk("R3 idle row bit6 mode", 32'(row_b), 32'd0);
        if (act_prev) begin
          void'(q_a.pop_front());
          void'(q_b.pop_front());
        end
      end
      act_prev = act;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n_seen;
    rst_n = 1'b0; act = 1'b0; cpu = 7'h7F;
    exp_a = '0; exp_b = '0; prev6_b = 1'b0;
    act_prev = 1'b0; mon_on = 1'b0; sweep_on = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    mon_on = 1'b1;

    // R1: first refresh after reset shows zero extension bits
    @(negedge clk);
    chk("R1 reset row", 32'(row_a), 32'd0);
    @(posedge clk); #1;

    // R10 sweep from reset, rows 0..127 repeating; R4/R5 via scoreboard
    sweep_on = 1'b1;
    for (int i = 0; i < ROWS; i++) refresh(7'(i), 1, 7'(i), 1);
    sweep_on = 1'b0;
    n_seen = 0;
    for (int i = 0; i < ROWS; i++) if (seen[i]) n_seen++;
    chk("R10 distinct rows", n_seen, ROWS);

    // R5: a second sweep wraps the extension from all ones back to zero
    for (int i = 0; i < ROWS; i++) refresh(7'(i), 1, 7'(i), 1);
    chk("R5 wrap model", 32'(exp_a), 32'd0);

    // R6: long strobes count once; mid-strobe row changes do not trigger
    refresh(7'h7F, 5, 7'h7F, 2);
    refresh(7'h10, 4, 7'h7F, 1);
    refresh(7'h7F, 3, 7'h00, 3);
    refresh(7'h05, 1, 7'h05, 1);

    // R7: matching row while idle, and non-matching rows, change nothing
    cpu = 7'h7F;
    repeat (6) begin @(posedge clk); #1; end
    refresh(7'h7E, 2, 7'h7E, 1);
    refresh(7'h00, 1, 7'h00, 1);
    refresh(7'h3F, 1, 7'h3F, 1);

    // R4/R9: sweep started out of phase at row 50, with longer gaps
    for (int i = 0; i < 300; i++) refresh(7'((50 + i) % 128), 2, 7'((50 + i) % 128), 2);

    repeat (3) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule